// File: doc/BRIEF.md
# Per-pixel mode-selectable hit counter

This block is the digital back end of one pixel in a counting imager. It receives an asynchronous discriminator output and a global shutter. It re-times both onto a shared reference clock. A per-pixel counter then advances according to one of five configurations chosen by three configuration bits. The pixel can be disabled, count discrete hits, measure how long the pulse stays above threshold, measure time from the first hit to the end of the exposure, or record only whether a hit arrived at all.

All counting is gated by the re-timed shutter, so the counter enable is always a clean registered signal. The counter is parameterised in width and defaults to 14 bits. When an increment is requested while the counter already holds its maximum, the counter saturates and a sticky overflow flag is raised. A synchronous clear input zeroes the counter, the flag and the per-window mode state between exposures.

Top module: `pixel_mode_counter`

## Requirements
- R1: With `cfg_mask` = 1 the counter and overflow flag never change, whatever `cfg_timed` and `cfg_first` hold and whatever the hit and shutter do.
- R2: Event mode (`cfg_mask`=0, `cfg_timed`=0, `cfg_first`=0): the counter advances by one for each rising edge of (hit AND shutter) after re-timing, so a hit already high when the shutter opens counts once.
- R3: Time-over-threshold mode (`cfg_mask`=0, `cfg_timed`=1, `cfg_first`=0): the counter advances once per reference-clock cycle in which both the re-timed hit and the re-timed shutter are high.
- R4: Arrival-time mode (`cfg_mask`=0, `cfg_timed`=1, `cfg_first`=1): from the first cycle with the hit high inside an open shutter, the counter advances every cycle until the shutter closes; later hits in the same window neither restart nor extend the count, and a closed shutter ends the window.
- R5: Single-hit mode (`cfg_mask`=0, `cfg_timed`=0, `cfg_first`=1): the counter advances once, on the first rising edge of (hit AND shutter); all later hits, in this or later windows, are ignored until `cnt_clear`.
- R6: Hit and shutter each pass through `SYNC_STAGES` flip-flops on `clk_ref`; a hit already high when the shutter opens counts from the first re-timed open cycle, and nothing counts while the re-timed shutter is low.
- R7: When the shutter closes while the hit is high, counting stops on the re-timed closing, so in time-over-threshold and arrival modes the count equals the number of open cycles counted.
- R8: An increment requested while the counter holds its maximum (all ones) leaves the counter at the maximum and sets `ovf_o`, which stays set until `cnt_clear`.
- R9: `cnt_clear` = 1 at a clock edge sets the counter to 0, clears `ovf_o` and forgets the single-hit and arrival state; it takes priority over any increment.
- R10: After `rst_n` is asserted the counter is 0 and `ovf_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Shared reference clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| hit_async | input | 1 | Discriminator output, asynchronous |
| shutter_async | input | 1 | Global exposure shutter, asynchronous |
| cfg_mask | input | 1 | 1 disables the pixel |
| cfg_timed | input | 1 | Mode bit: 1 selects clock-based counting |
| cfg_first | input | 1 | Mode bit: 1 selects first-hit behaviour |
| cnt_clear | input | 1 | Synchronous counter clear |
| count_o | output | CNT_W | Counter value |
| ovf_o | output | 1 | Sticky overflow flag |

## Verification
The bench builds the block with `CNT_W` = 6 and `SYNC_STAGES` = 2. The 6-bit counter brings saturation at 63 within a window of a few dozen cycles, so the exact boundary between 63 increments and 64 is checked directly. Random windows also cross the limit often. Two synchronizer stages keep hit and shutter equally delayed, so per-window totals can be predicted from the driven sequence alone.

// File: rtl/pmc_pkg.sv
package pmc_pkg;

  typedef enum logic [2:0] {
    PM_MASKED  = 3'd0,
    PM_EVENT   = 3'd1,
    PM_TOT     = 3'd2,
    PM_ARRIVAL = 3'd3,
    PM_SINGLE  = 3'd4
  } pix_mode_e;

  function automatic pix_mode_e decode_mode(input logic mask,
                                            input logic timed,
                                            input logic first);
    pix_mode_e m;
    if (mask) begin
      m = PM_MASKED;
    end else begin
      case ({timed, first})
        2'b00:   m = PM_EVENT;
        2'b10:   m = PM_TOT;
        2'b11:   m = PM_ARRIVAL;
        default: m = PM_SINGLE;
      endcase
    end
    return m;
  endfunction

endpackage

// File: rtl/pmc_sync.sv
module pmc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic q_sync
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        assign chain_d[g] = d_async;
      end else begin : g_next
        assign chain_d[g] = chain_q[g-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q[g] <= 1'b0;
        else        chain_q[g] <= chain_d[g];
      end
    end
  endgenerate

  assign q_sync = chain_q[STAGES-1];

endmodule

// File: rtl/pmc_gate.sv
module pmc_gate
  import pmc_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  pix_mode_e mode,
  input  logic      hit_s,
  input  logic      shut_s,
  input  logic      clr,
  output logic      inc_o
);

  logic lvl;
  logic lvl_q, lvl_d;
  logic armed_q, armed_d;
  logic done_q, done_d;
  logic rise;

  assign lvl  = hit_s & shut_s;
  assign rise = lvl & ~lvl_q;

  always_comb begin
    inc_o   = 1'b0;
    lvl_d   = lvl;
    armed_d = armed_q;
    done_d  = done_q;

    if (!shut_s)    armed_d = 1'b0;
    else if (hit_s) armed_d = 1'b1;

    case (mode)
      PM_EVENT:   inc_o = rise;
      PM_TOT:     inc_o = lvl;
      PM_ARRIVAL: inc_o = shut_s & (armed_q | hit_s);
      PM_SINGLE:  inc_o = rise & ~done_q;
      default:    inc_o = 1'b0;
    endcase

    if (mode == PM_SINGLE && inc_o) done_d = 1'b1;

    if (clr) begin
      armed_d = 1'b0;
      done_d  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q   <= 1'b0;
      armed_q <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      lvl_q   <= lvl_d;
      armed_q <= armed_d;
      done_q  <= done_d;
    end
  end

  // R6
  shut_closed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !shut_s |-> !inc_o);

  // R5
  single_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == PM_SINGLE && done_q) |-> !inc_o);

  // R4
  arrival_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == PM_ARRIVAL && armed_q && shut_s) |-> inc_o);

  // R1
  masked_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == PM_MASKED) |-> !inc_o);

endmodule

// File: rtl/pmc_counter.sv
module pmc_counter #(
  parameter int W = 14
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] cnt_o,
  output logic         ovf_o
);

  localparam logic [W-1:0] MAX = '1;

  logic [W-1:0] cnt_q, cnt_d;
  logic         ovf_q, ovf_d;
  logic         at_max;

  assign at_max = (cnt_q == MAX);

  always_comb begin
    cnt_d = cnt_q;
    ovf_d = ovf_q;
    if (clr) begin
      cnt_d = '0;
      ovf_d = 1'b0;
    end else if (inc) begin
      if (at_max) ovf_d = 1'b1;
      else        cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      ovf_q <= ovf_d;
    end
  end

  assign cnt_o = cnt_q;
  assign ovf_o = ovf_q;

  // R8
  sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == MAX && !clr) |=> (cnt_q == MAX));

  // R8
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_q && !clr) |=> ovf_q);

  // R8
  ovf_at_max_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf_q) |-> (cnt_q == MAX));

  // R9
  clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt_q == '0 && !ovf_q));

  // R2
  step_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) + 1'b1));

endmodule

// File: rtl/pixel_mode_counter.sv
module pixel_mode_counter
  import pmc_pkg::*;
#(
  parameter int CNT_W       = 14,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_ref,
  input  logic             rst_n,
  input  logic             hit_async,
  input  logic             shutter_async,
  input  logic             cfg_mask,
  input  logic             cfg_timed,
  input  logic             cfg_first,
  input  logic             cnt_clear,
  output logic [CNT_W-1:0] count_o,
  output logic             ovf_o
);

  logic      hit_s;
  logic      shut_s;
  logic      inc;
  pix_mode_e mode;

  assign mode = decode_mode(cfg_mask, cfg_timed, cfg_first);

  pmc_sync #(.STAGES(SYNC_STAGES)) u_hit_sync (
    .clk     (clk_ref),
    .rst_n   (rst_n),
    .d_async (hit_async),
    .q_sync  (hit_s)
  );

  pmc_sync #(.STAGES(SYNC_STAGES)) u_shut_sync (
    .clk     (clk_ref),
    .rst_n   (rst_n),
    .d_async (shutter_async),
    .q_sync  (shut_s)
  );

  pmc_gate u_gate (
    .clk    (clk_ref),
    .rst_n  (rst_n),
    .mode   (mode),
    .hit_s  (hit_s),
    .shut_s (shut_s),
    .clr    (cnt_clear),
    .inc_o  (inc)
  );

  pmc_counter #(.W(CNT_W)) u_cnt (
    .clk   (clk_ref),
    .rst_n (rst_n),
    .clr   (cnt_clear),
    .inc   (inc),
    .cnt_o (count_o),
    .ovf_o (ovf_o)
  );

  // R1
  mask_freeze_chk: assert property (@(posedge clk_ref) disable iff (!rst_n)
    (cfg_mask && !cnt_clear) |=> ($stable(count_o) && $stable(ovf_o)));

endmodule

// File: tb/pixel_mode_counter_tb_top.sv
module pixel_mode_counter_tb_top;

  localparam int CNT_W = 6;
  localparam int SYNC  = 2;
  localparam int MAXV  = (1 << CNT_W) - 1;

  logic             clk_ref = 1'b0;
  logic             rst_n;
  logic             hit_async, shutter_async;
  logic             cfg_mask, cfg_timed, cfg_first, cnt_clear;
  logic [CNT_W-1:0] count_o;
  logic             ovf_o;

  int n_chk = 0;
  int n_bad = 0;
  int cyc   = 0;

  // bench model state
  int m_cnt, m_ovf, m_plv, m_armed, m_done;

  always #4 clk_ref = ~clk_ref;
  always @(posedge clk_ref) cyc <= cyc + 1;

  pixel_mode_counter #(.CNT_W(CNT_W), .SYNC_STAGES(SYNC)) dut_i (
    .clk_ref(clk_ref), .rst_n(rst_n), .hit_async(hit_async),
    .shutter_async(shutter_async), .cfg_mask(cfg_mask),
    .cfg_timed(cfg_timed), .cfg_first(cfg_first), .cnt_clear(cnt_clear),
    .count_o(count_o), .ovf_o(ovf_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // spec-level per-cycle model step on driven values
  function automatic void model_step(input int h, input int s);
    int lvl, rise, inc;
    lvl  = h & s;
    rise = lvl & (m_plv ^ 1);
    inc  = 0;
    if (!cfg_mask) begin
      case ({cfg_timed, cfg_first})
        2'b00: inc = rise;
        2'b10: inc = lvl;
        2'b11: inc = s & (m_armed | h);
        default: inc = rise & (m_done ^ 1);
      endcase
      if ({cfg_timed, cfg_first} == 2'b01 && inc != 0) m_done = 1;
    end
    if (!s) m_armed = 0; else if (h) m_armed = 1;
    m_plv = lvl;
    if (inc != 0) begin
      if (m_cnt == MAXV) m_ovf = 1; else m_cnt++;
    end
  endfunction

  task automatic drive(input int h, input int s);
    @(negedge clk_ref);
    hit_async     = h[0];
    shutter_async = s[0];
    model_step(h, s);
  endtask

  task automatic settle();
    for (int i = 0; i < SYNC + 3; i++) drive(0, 0);
  endtask

  task automatic do_clear();
    @(negedge clk_ref);
    cnt_clear = 1'b1;
    @(negedge clk_ref);
    cnt_clear = 1'b0;
    m_cnt = 0; m_ovf = 0; m_armed = 0; m_done = 0;
  endtask

  task automatic set_mode(input logic mk, input logic tm, input logic fs);
    @(negedge clk_ref);
    cfg_mask = mk; cfg_timed = tm; cfg_first = fs;
  endtask

  task automatic hold(input int h, input int s, input int n);
    for (int i = 0; i < n; i++) drive(h, s);
  endtask

  initial begin : watchdog
    wait (cyc > 150000);
    n_bad++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin : stim
    void'($urandom(32'd4711));
    rst_n = 1'b0; hit_async = 0; shutter_async = 0;
    cfg_mask = 0; cfg_timed = 0; cfg_first = 0; cnt_clear = 0;
    m_cnt = 0; m_ovf = 0; m_plv = 0; m_armed = 0; m_done = 0;
    repeat (3) @(negedge clk_ref);
    rst_n = 1'b1;
    @(negedge clk_ref);
    chk("R10 count", int'(count_o), 0);
    chk("R10 ovf", int'(ovf_o), 0);

    // R1: masked pixel with all mode bit combinations
    for (int k = 0; k < 4; k++) begin
      set_mode(1'b1, k[1], k[0]);
      hold(1, 1, 5); hold(0, 1, 3); hold(1, 1, 4);
      settle();
      chk("R1 masked count", int'(count_o), 0);
    end

    // R2: event mode, three pulses
    set_mode(0, 0, 0); do_clear();
    hold(0, 1, 2);
    for (int p = 0; p < 3; p++) begin hold(1, 1, 3); hold(0, 1, 2); end
    hold(0, 0, 1); hold(1, 0, 3);
    settle();
    chk("R2 event pulses", int'(count_o), 3);

    // R2/R6: hit already high when shutter opens counts once
    do_clear();
    hold(1, 0, 3); hold(1, 1, 3); hold(0, 1, 3); hold(1, 1, 2);
    settle();
    chk("R2 event hit-at-open", int'(count_o), 2);

    // R3: time-over-threshold
    set_mode(0, 1, 0); do_clear();
    hold(0, 1, 2); hold(1, 1, 7); hold(0, 1, 4); hold(1, 1, 5);
    settle();
    chk("R3 tot", int'(count_o), 12);

    // R6/R7: hit high before opening and after closing
    do_clear();
    hold(1, 0, 3); hold(1, 1, 8); hold(1, 0, 3);
    settle();
    chk("R7 tot close with hit high", int'(count_o), 8);

    // R4: arrival, second hit does not restart
    set_mode(0, 1, 1); do_clear();
    hold(0, 1, 5); hold(1, 1, 2); hold(0, 1, 3); hold(1, 1, 2); hold(0, 1, 8);
    settle();
    chk("R4 arrival", int'(count_o), 15);

    // R4/R7: arrival stops at closing with hit high
    do_clear();
    hold(1, 1, 10); hold(1, 0, 5);
    settle();
    chk("R7 arrival close", int'(count_o), 10);

    // R5: single hit, later hits and windows ignored
    set_mode(0, 0, 1); do_clear();
    hold(0, 1, 2);
    for (int p = 0; p < 3; p++) begin hold(1, 1, 2); hold(0, 1, 2); end
    settle();
    chk("R5 single first window", int'(count_o), 1);
    hold(1, 1, 3); hold(0, 1, 2); hold(1, 1, 3);
    settle();
    chk("R5 single later window", int'(count_o), 1);

    // R8: saturation boundary
    set_mode(0, 1, 0); do_clear();
    hold(1, 1, MAXV);
    settle();
    chk("R8 at max count", int'(count_o), MAXV);
    chk("R8 at max no ovf", int'(ovf_o), 0);
    hold(1, 1, 1);
    settle();
    chk("R8 past max count", int'(count_o), MAXV);
    chk("R8 past max ovf", int'(ovf_o), 1);
    hold(1, 1, 10);
    settle();
    chk("R8 ovf sticky", int'(ovf_o), 1);

    // R9: clear
    do_clear();
    @(negedge clk_ref);
    chk("R9 clear count", int'(count_o), 0);
    chk("R9 clear ovf", int'(ovf_o), 0);

    // random windows against bench model
    for (int w = 0; w < 60; w++) begin
      int md, len, h, s;
      md = $urandom_range(0, 4);
      if (md == 4) set_mode(1, $urandom_range(0, 1), $urandom_range(0, 1));
      else         set_mode(0, md[1], md[0]);
      if ($urandom_range(0, 1) == 1) do_clear();
      len = $urandom_range(10, 70);
      h = 0; s = 0;
      for (int c = 0; c < len; c++) begin
        if ($urandom_range(0, 3) == 0) h = h ^ 1;
        if ($urandom_range(0, 9) == 0) s = s ^ 1;
        drive(h, s);
      end
      settle();
      chk("R2-mode random count", int'(count_o), m_cnt);
      chk("R8 random ovf", int'(ovf_o), m_ovf);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule